// File: doc/BRIEF.md
# Control Input Conditioner for a PWM Generator

This block prepares the external control signal that a PWM generator uses to gate, blank or terminate its pulses. A select field picks one line out of a bank of asynchronous candidate inputs. The chosen line is synchronized, optionally inverted, optionally forced active by software, and then registered. A mode bit can defer every change of the conditioned source to the next PWM end-of-cycle strobe, so a gating signal never cuts a pulse in the middle. A one-cycle pulse marks each high-to-low transition of the conditioned source, and a downstream termination selector can use it as an automatic termination event.

A second path builds a qualifier signal. A 3-bit code picks the qualifier from duty-cycle-active, blanking-active, generator-triggered, one of eight PWM outputs, or a synchronized external line. The qualifier has its own inversion and software force. Code zero turns qualification off, so the qualifier reads true. A 3-bit pick field selects which PWM output feeds the qualifier selector. The same selected PWM output is also presented registered, so that termination selectors outside this block can use it. The acceptance latch that combines these signals is not part of this block, and neither is the PWM counter.

Top module: `ctlin_shaper`

## Requirements
- R1: While rstN is low, srcOut, qualOut, fallPulse and pwmPicked are all 0.
- R2: With srcEocSync=0, srcOut follows srcIn[srcSel]. A change on a srcIn line appears on srcOut after exactly three rising clock edges (two synchronizer flops plus the output register). A change of srcSel, srcInvert or srcForce appears after one edge.
- R3: With srcInvert=1, srcOut carries the complement of the selected line.
- R4: With srcForce=1, the conditioned source is 1 whatever the selected line and srcInvert are.
- R5: With srcEocSync=1, srcOut loads a new value only at a rising edge where eocStrobe is sampled high. At every other edge it holds its value.
- R6: fallPulse is 1 for exactly those clock cycles in which srcOut has just changed from 1 to 0. A rising srcOut never produces a pulse.
- R7: qualSel codes pick the raw qualifier: 1 dutyActive, 2 blankActive, 3 genTriggered, 4 pwmOuts[pwmPick], 5 extQual. Codes 6 and 7 give a raw 0. The conditioned qualifier is qualForce OR (raw XOR qualInvert), and it is registered with one edge of latency.
- R8: With qualSel=0, qualOut is 1 one edge later, regardless of qualInvert and qualForce.
- R9: qualInvert and qualForce act on the qualifier only, and srcInvert and srcForce act on the source only.
- R10: pwmPicked equals pwmOuts[pwmPick] one rising edge after the inputs are applied.
- R11: extQual passes through a two-flop synchronizer. With qualSel=5, a change on extQual reaches qualOut after exactly three rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | N_SRC | Asynchronous candidate source lines |
| srcSel | input | SEL_W | Index of the source line to use |
| srcInvert | input | 1 | Invert the selected source |
| srcForce | input | 1 | Software force of the source to active |
| srcEocSync | input | 1 | Defer source changes to the end-of-cycle strobe |
| eocStrobe | input | 1 | Single-cycle PWM end-of-cycle strobe |
| qualSel | input | 3 | Qualifier code (0 off, 1 duty, 2 blank, 3 trig, 4 PWM, 5 ext) |
| qualInvert | input | 1 | Invert the raw qualifier |
| qualForce | input | 1 | Software force of the qualifier to active |
| dutyActive | input | 1 | Duty-cycle-active status from the generator |
| blankActive | input | 1 | Leading-edge blanking active status |
| genTriggered | input | 1 | Generator-triggered status |
| pwmOuts | input | N_PWM | PWM outputs available for routing |
| pwmPick | input | PICK_W | Index of the PWM output to route |
| extQual | input | 1 | Asynchronous external qualifier line |
| srcOut | output | 1 | Conditioned source |
| qualOut | output | 1 | Conditioned qualifier |
| fallPulse | output | 1 | One-cycle pulse on a source falling edge |
| pwmPicked | output | 1 | Registered selected PWM output for terminator selectors |

## Verification
The assertions check four properties on every cycle. The edge pulse is one cycle long and appears only when srcOut has just dropped. srcOut holds between end-of-cycle strobes while deferral is enabled. A software force drives its output active one edge later. Qualifier code zero reads true. The bench scenarios cover what a single-cycle property cannot see: that the right line of the source bank and the right qualifier code are picked, the exact three-edge latency through the synchronizers, the inversion truth tables, and that a deferred change appears on the edge of the strobe.

// File: rtl/ctlin_pkg.sv
package ctlin_pkg;

  localparam int QUAL_W = 3;

  typedef enum logic [QUAL_W-1:0] {
    QUAL_NONE  = 3'd0,
    QUAL_DUTY  = 3'd1,
    QUAL_BLANK = 3'd2,
    QUAL_TRIG  = 3'd3,
    QUAL_PWM   = 3'd4,
    QUAL_EXT   = 3'd5
  } qualCode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSrc;     // source output register may take a new value
    logic qualBypass;  // qualification switched off
  } ctlStrobe_t;

endpackage

// File: rtl/ctlin_sync.sv
module ctlin_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : gChain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= '0;
      else       stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/ctlin_ctrl.sv
module ctlin_ctrl
  import ctlin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcEocSync,
  input  logic              eocStrobe,
  input  logic [QUAL_W-1:0] qualSel,
  input  logic              srcCond,
  input  logic              srcNow,
  output ctlStrobe_t        strobe,
  output logic              fallPulse
);

  always_comb begin
    strobe.loadSrc    = !srcEocSync || eocStrobe;
    strobe.qualBypass = (qualCode_e'(qualSel) == QUAL_NONE);
  end

  // The pulse rises on the same edge where the source register drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fallPulse <= 1'b0;
    else       fallPulse <= strobe.loadSrc && srcNow && !srcCond;
  end

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse |=> !fallPulse); // R6
  AST_FALL_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse |-> (!srcNow && $past(srcNow))); // R6

endmodule

// File: rtl/ctlin_datapath.sv
module ctlin_datapath
  import ctlin_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int N_PWM       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(N_SRC),
  localparam int PICK_W     = $clog2(N_PWM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  srcIn,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic              srcInvert,
  input  logic              srcForce,
  input  logic [QUAL_W-1:0] qualSel,
  input  logic              qualInvert,
  input  logic              qualForce,
  input  logic              dutyActive,
  input  logic              blankActive,
  input  logic              genTriggered,
  input  logic [N_PWM-1:0]  pwmOuts,
  input  logic [PICK_W-1:0] pwmPick,
  input  logic              extQual,
  input  ctlStrobe_t        strobe,
  output logic              srcCond,
  output logic              srcOut,
  output logic              qualOut,
  output logic              pwmPicked
);

  logic [N_SRC:0] asyncBundle;
  logic [N_SRC:0] syncBundle;
  logic           srcPicked;
  logic           pwmSel;
  logic           qualRaw;
  logic           qualCond;

  assign asyncBundle = {extQual, srcIn};

  ctlin_sync #(.WIDTH(N_SRC + 1), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (asyncBundle),
    .dout (syncBundle)
  );

  always_comb begin
    srcPicked = syncBundle[srcSel];
    srcCond   = srcForce | (srcPicked ^ srcInvert);
    pwmSel    = pwmOuts[pwmPick];
    case (qualCode_e'(qualSel))
      QUAL_DUTY:  qualRaw = dutyActive;
      QUAL_BLANK: qualRaw = blankActive;
      QUAL_TRIG:  qualRaw = genTriggered;
      QUAL_PWM:   qualRaw = pwmSel;
      QUAL_EXT:   qualRaw = syncBundle[N_SRC];
      default:    qualRaw = 1'b0;
    endcase
    qualCond = strobe.qualBypass | qualForce | (qualRaw ^ qualInvert);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcOut    <= 1'b0;
      qualOut   <= 1'b0;
      pwmPicked <= 1'b0;
    end else begin
      if (strobe.loadSrc) srcOut <= srcCond;
      qualOut   <= qualCond;
      pwmPicked <= pwmSel;
    end
  end

endmodule

// File: rtl/ctlin_shaper.sv
module ctlin_shaper
  import ctlin_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int N_PWM       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(N_SRC),
  localparam int PICK_W     = $clog2(N_PWM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  srcIn,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic              srcInvert,
  input  logic              srcForce,
  input  logic              srcEocSync,
  input  logic              eocStrobe,
  input  logic [QUAL_W-1:0] qualSel,
  input  logic              qualInvert,
  input  logic              qualForce,
  input  logic              dutyActive,
  input  logic              blankActive,
  input  logic              genTriggered,
  input  logic [N_PWM-1:0]  pwmOuts,
  input  logic [PICK_W-1:0] pwmPick,
  input  logic              extQual,
  output logic              srcOut,
  output logic              qualOut,
  output logic              fallPulse,
  output logic              pwmPicked
);

  ctlStrobe_t strobe;
  logic       srcCond;

  ctlin_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .srcEocSync (srcEocSync),
    .eocStrobe  (eocStrobe),
    .qualSel    (qualSel),
    .srcCond    (srcCond),
    .srcNow     (srcOut),
    .strobe     (strobe),
    .fallPulse  (fallPulse)
  );

  ctlin_datapath #(
    .N_SRC       (N_SRC),
    .N_PWM       (N_PWM),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .srcIn        (srcIn),
    .srcSel       (srcSel),
    .srcInvert    (srcInvert),
    .srcForce     (srcForce),
    .qualSel      (qualSel),
    .qualInvert   (qualInvert),
    .qualForce    (qualForce),
    .dutyActive   (dutyActive),
    .blankActive  (blankActive),
    .genTriggered (genTriggered),
    .pwmOuts      (pwmOuts),
    .pwmPick      (pwmPick),
    .extQual      (extQual),
    .strobe       (strobe),
    .srcCond      (srcCond),
    .srcOut       (srcOut),
    .qualOut      (qualOut),
    .pwmPicked    (pwmPicked)
  );

  AST_EOC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (srcEocSync && !eocStrobe) |=> $stable(srcOut)); // R5
  AST_SRC_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (srcForce && !srcEocSync) |=> srcOut); // R4
  AST_QUAL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (qualSel == 3'd0) |=> qualOut); // R8
  AST_QUAL_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    qualForce |=> qualOut); // R9

endmodule

// File: tb/sim_ctlin_shaper.sv
module sim_ctlin_shaper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [4:0]  srcSel = '0;
  logic        srcInvert = 1'b0;
  logic        srcForce = 1'b0;
  logic        srcEocSync = 1'b0;
  logic        eocStrobe = 1'b0;
  logic [2:0]  qualSel = '0;
  logic        qualInvert = 1'b0;
  logic        qualForce = 1'b0;
  logic        dutyActive = 1'b1;
  logic        blankActive = 1'b0;
  logic        genTriggered = 1'b1;
  logic [7:0]  pwmOuts = 8'hA5;
  logic [2:0]  pwmPick = 3'd1;
  logic        extQual = 1'b0;
  logic        srcOut, qualOut, fallPulse, pwmPicked;

  int checkCount = 0;
  int failCount = 0;
  int cycleCount = 0;

  always #2 clk = ~clk;

  ctlin_shaper u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .srcSel(srcSel),
    .srcInvert(srcInvert), .srcForce(srcForce), .srcEocSync(srcEocSync),
    .eocStrobe(eocStrobe), .qualSel(qualSel), .qualInvert(qualInvert),
    .qualForce(qualForce), .dutyActive(dutyActive), .blankActive(blankActive),
    .genTriggered(genTriggered), .pwmOuts(pwmOuts), .pwmPick(pwmPick),
    .extQual(extQual), .srcOut(srcOut), .qualOut(qualOut),
    .fallPulse(fallPulse), .pwmPicked(pwmPicked)
  );

  typedef struct packed {
    logic [4:0] sel;
    logic       inv;
    logic       frc;
    logic       line;
    logic [2:0] qsel;
    logic       qinv;
    logic       qfrc;
    logic       expS;
    logic       expQ;
  } vec_t;

  // Fixed qualifier inputs: duty=1 blank=0 trig=1 pwmOuts[1]=0 ext=0
  localparam vec_t VECS [13] = '{
    '{5'd3,  1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{5'd3,  1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd17, 1'b1, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    '{5'd17, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1},
    '{5'd31, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0},
    '{5'd0,  1'b1, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0},
    '{5'd0,  1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1},
    '{5'd8,  1'b0, 1'b0, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd8,  1'b0, 1'b0, 1'b1, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0},
    '{5'd20, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1},
    '{5'd20, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{5'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{5'd5,  1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    check(srcOut, 1'b0, "R1 srcOut");
    check(qualOut, 1'b0, "R1 qualOut");
    check(fallPulse, 1'b0, "R1 fallPulse");
    check(pwmPicked, 1'b0, "R1 pwmPicked");
    rstN = 1'b1;
    tick(2);

    // Table walk: R2 R3 R4 on source, R7 R8 R9 on qualifier
    for (int i = 0; i < 13; i++) begin
      srcSel     = VECS[i].sel;
      srcInvert  = VECS[i].inv;
      srcForce   = VECS[i].frc;
      srcIn      = VECS[i].line ? (32'h1 << VECS[i].sel) : ~(32'h1 << VECS[i].sel);
      qualSel    = VECS[i].qsel;
      qualInvert = VECS[i].qinv;
      qualForce  = VECS[i].qfrc;
      tick(4);
      check(srcOut, VECS[i].expS, $sformatf("R2 R3 R4 vector %0d", i));
      check(qualOut, VECS[i].expQ, $sformatf("R7 R8 R9 vector %0d", i));
    end

    // R2 latency from a source line
    srcSel = 5'd9; srcInvert = 0; srcForce = 0; srcIn = '0;
    qualSel = 3'd1; qualInvert = 0; qualForce = 0;
    tick(4);
    srcIn = 32'h1 << 9;
    tick(2);
    check(srcOut, 1'b0, "R2 two edges");
    tick(1);
    check(srcOut, 1'b1, "R2 three edges");

    // R11 external qualifier latency
    qualSel = 3'd5; extQual = 1'b0;
    tick(4);
    extQual = 1'b1;
    tick(2);
    check(qualOut, 1'b0, "R11 two edges");
    tick(1);
    check(qualOut, 1'b1, "R11 three edges");

    // R10 PWM output routing
    for (int p = 0; p < 8; p++) begin
      pwmPick = p[2:0];
      tick(1);
      check(pwmPicked, pwmOuts[p], $sformatf("R10 pick %0d", p));
    end
    pwmOuts = 8'h5A;
    tick(1);
    check(pwmPicked, 1'b0, "R10 update");

    // R6 edge pulse without deferral
    srcIn = '0; srcSel = 5'd5; srcForce = 1'b1;
    tick(4);
    check(fallPulse, 1'b0, "R6 no pulse on rise");
    srcForce = 1'b0;
    tick(1);
    check(srcOut, 1'b0, "R6 source dropped");
    check(fallPulse, 1'b1, "R6 pulse");
    tick(1);
    check(fallPulse, 1'b0, "R6 pulse ends");

    // R5 deferral to end of cycle
    srcEocSync = 1'b1; srcForce = 1'b1;
    tick(5);
    check(srcOut, 1'b0, "R5 held before strobe");
    eocStrobe = 1'b1;
    tick(1);
    eocStrobe = 1'b0;
    check(srcOut, 1'b1, "R5 loaded on strobe");
    srcForce = 1'b0;
    tick(3);
    check(srcOut, 1'b1, "R5 held high");
    check(fallPulse, 1'b0, "R6 no pulse while held");
    eocStrobe = 1'b1;
    tick(1);
    eocStrobe = 1'b0;
    check(srcOut, 1'b0, "R5 dropped on strobe");
    check(fallPulse, 1'b1, "R6 pulse on deferred drop");
    tick(1);
    check(fallPulse, 1'b0, "R6 deferred pulse ends");

    finishRun();
  end

endmodule